// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Recording

This block sits behind a page-table walker. It decides whether a single memory access may go ahead on the page that the walker has just resolved. Each access is described by three things: its kind (load, store, instruction fetch, or a combined store-plus-fetch), whether the processor is in supervisor mode, and the 3-bit permission code from the final page entry. From these the block forms a 3-bit access index. It looks that index up against the permission code in a fixed 8x8 matrix and produces a fault code. It also tells the mapping logic whether the page may be installed as writeable.

When the walker has already failed (invalid entry or translation error), its fault type is taken in place of the permission result. Every fault is recorded, whatever the trap setting. The status register holds the access index, the fault type, an address-valid bit, and an overflow bit that marks a second fault arriving before software read the first. The address register captures the full faulting virtual address. A trap request is raised for a fault only when no-fault mode is off and traps are enabled. Software reads the status register through a one-cycle read strobe, and that read clears it.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is {store, fetch, supervisor}. Bit 2 is set for a store, bit 1 for an instruction fetch and bit 0 for a supervisor access; a store with fetch also set uses indices 6 and 7.
- R2: With `chk_valid` high and `walk_fault` zero, `fault_code` equals matrix[index][perm] in the same cycle (0 = allowed, 2 = protection, 3 = privilege). The matrix rows for indices 0 to 7, listed for perm 0..7, are {0,0,0,0,2,0,3,3}, {0,0,0,0,2,0,0,0}, {2,2,0,0,0,2,3,3}, {2,2,0,0,0,2,0,0}, {2,0,2,0,2,2,3,3}, {2,0,2,0,2,0,2,0}, {2,2,2,0,2,2,3,3}, {2,2,2,0,2,2,2,0}. With `chk_valid` low, `fault_code` is 0 and no register changes.
- R3: A nonzero `walk_fault` (1 = invalid entry, 4 = translation error) overrides the matrix. It appears unchanged on `fault_code` and in the status encoding.
- R4: `write_grant` is high only for an access that is valid and has no fault, when the page's modified bit is set and either perm is 1, 3, 5 or 7 for a supervisor access, or perm is 1 or 3 for a user access.
- R5: On a fault, the status register is first set to 1 if it was nonzero (overflow in bit 0). It is then ORed with index<<5 | fault<<2 | 2, so bits 7:5 hold the index, bits 4:2 the fault type and bit 1 the address-valid flag.
- R6: On a fault, `far_q` loads `vaddr` at the next edge; otherwise it holds its value.
- R7: `trap_req` is high in the fault cycle only when `nofault_mode` is 0 and `traps_en` is 1. Both registers update regardless.
- R8: A cycle with `fsr_rd` high and no fault clears `fsr_q` to 0 at the next edge.
- R9: A fault in the same cycle as `fsr_rd` is recorded on top of the cleared value, so no overflow bit is set and the new fault is kept.
- R10: After reset, `fsr_q` and `far_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | An access is presented this cycle |
| acc_store | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is made in supervisor mode |
| perm | input | 3 | Permission code of the final page entry |
| page_mod | input | 1 | Modified bit of the final page entry |
| walk_fault | input | 3 | Walker fault type, 0 when the walk succeeded |
| vaddr | input | VA_W | Virtual address of the access |
| nofault_mode | input | 1 | Suppress trap requests |
| traps_en | input | 1 | Processor traps are enabled |
| fsr_rd | input | 1 | Software read of the status register (clears it) |
| fault_code | output | 3 | Fault type for the current access |
| write_grant | output | 1 | Mapping may be installed writeable |
| trap_req | output | 1 | Request a trap for the current fault |
| fsr_q | output | 8 | Fault status register |
| far_q | output | VA_W | Fault address register |

## Verification
Two functions can fall in the same cycle: the clear-on-read of the status register and the recording of a new fault. The bench first leaves a fault in the register. It then presents a second faulting access in the same cycle as the read strobe. The register after that edge must hold only the new fault's fields with the overflow bit clear. Without the read, the same second fault must set the overflow bit.

// File: rtl/mmu_access_guard.sv
module mmu_access_guard #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_valid,
  input  logic            acc_store,
  input  logic            acc_fetch,
  input  logic            acc_super,
  input  logic [2:0]      perm,
  input  logic            page_mod,
  input  logic [2:0]      walk_fault,
  input  logic [VA_W-1:0] vaddr,
  input  logic            nofault_mode,
  input  logic            traps_en,
  input  logic            fsr_rd,
  output logic [2:0]      fault_code,
  output logic            write_grant,
  output logic            trap_req,
  output logic [7:0]      fsr_q,
  output logic [VA_W-1:0] far_q
);

  // each row: two bits per permission code, code 0 in the low bits
  localparam logic [15:0] RIGHTS [8] = '{
    16'hF200, 16'h0200, 16'hF80A, 16'h080A,
    16'hFA22, 16'h2222, 16'hFA2A, 16'h2A2A
  };

  logic [2:0] acc_idx;
  logic [1:0] mat_code;
  logic       fault_ev;
  logic [7:0] fsr_base;

  assign acc_idx    = {acc_store, acc_fetch, acc_super};
  assign mat_code   = RIGHTS[acc_idx][{perm, 1'b0} +: 2];
  assign fault_code = !chk_valid          ? 3'd0 :
                      (walk_fault != 3'd0) ? walk_fault : {1'b0, mat_code};
  assign fault_ev   = chk_valid && (fault_code != 3'd0);

  assign write_grant = chk_valid && !fault_ev && page_mod && perm[0]
                       && (acc_super || !perm[2]);

  assign trap_req = fault_ev && !nofault_mode && traps_en;

  always_comb begin
    fsr_base = fsr_rd ? 8'd0 : fsr_q;
    if (fsr_base != 8'd0) fsr_base = 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (fault_ev) begin
      fsr_q <= fsr_base | {acc_idx, fault_code, 2'b10};
      far_q <= vaddr;
    end else if (fsr_rd) begin
      fsr_q <= '0;
    end
  end

  a_r4_grant_clean: assert property (@(posedge clk) disable iff (!rst_n)
    write_grant |-> (page_mod && fault_code == 3'd0 && perm[0]));

  a_r7_trap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!nofault_mode && traps_en && fault_code != 3'd0));

  a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && !fsr_rd && fsr_q != 8'd0) |=> (fsr_q[0] && fsr_q[1]));

  a_r6_far_load: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> (far_q == $past(vaddr)));

  a_r6_far_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_ev |=> $stable(far_q));

  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_rd && !fault_ev) |=> (fsr_q == 8'd0));

  a_r9_read_and_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_rd && fault_ev) |=> (!fsr_q[0] && fsr_q[1]));

endmodule

// File: tb/mmu_access_guard_tb.sv
module mmu_access_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0, acc_store = 1'b0, acc_fetch = 1'b0, acc_super = 1'b0;
  logic [2:0]  perm = '0;
  logic        page_mod = 1'b0;
  logic [2:0]  walk_fault = '0;
  logic [31:0] vaddr = '0;
  logic        nofault_mode = 1'b0, traps_en = 1'b1, fsr_rd = 1'b0;
  logic [2:0]  fault_code;
  logic        write_grant, trap_req;
  logic [7:0]  fsr_q;
  logic [31:0] far_q;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mmu_access_guard u_dut (.*);

  // {store, fetch, super, perm[2:0], mod, exp_fault[2:0], exp_grant}
  localparam logic [10:0] VEC [18] = '{
    {3'b000, 3'd0, 1'b1, 3'd0, 1'b0},
    {3'b000, 3'd4, 1'b1, 3'd2, 1'b0},
    {3'b000, 3'd6, 1'b1, 3'd3, 1'b0},
    {3'b001, 3'd6, 1'b1, 3'd0, 1'b0},
    {3'b010, 3'd0, 1'b1, 3'd2, 1'b0},
    {3'b010, 3'd2, 1'b1, 3'd0, 1'b0},
    {3'b011, 3'd7, 1'b1, 3'd0, 1'b1},
    {3'b100, 3'd1, 1'b1, 3'd0, 1'b1},
    {3'b100, 3'd5, 1'b1, 3'd2, 1'b0},
    {3'b100, 3'd3, 1'b0, 3'd0, 1'b0},
    {3'b101, 3'd5, 1'b1, 3'd0, 1'b1},
    {3'b101, 3'd4, 1'b1, 3'd2, 1'b0},
    {3'b110, 3'd3, 1'b1, 3'd0, 1'b1},
    {3'b111, 3'd6, 1'b1, 3'd2, 1'b0},
    {3'b001, 3'd5, 1'b1, 3'd0, 1'b1},
    {3'b000, 3'd5, 1'b1, 3'd0, 1'b0},
    {3'b101, 3'd7, 1'b1, 3'd0, 1'b1},
    {3'b000, 3'd7, 1'b1, 3'd3, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] kind, input logic [2:0] p,
                       input logic m, input logic [2:0] wf, input logic [31:0] va);
    @(negedge clk);
    chk_valid = v; {acc_store, acc_fetch, acc_super} = kind;
    perm = p; page_mod = m; walk_fault = wf; vaddr = va;
    #1;
  endtask

  task automatic idle_clear();
    drive(1'b0, 3'b000, 3'd0, 1'b0, 3'd0, 32'h0);
    fsr_rd = 1'b1;
    @(negedge clk);
    fsr_rd = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 fsr after reset", fsr_q, 0);
    check("R10 far after reset", far_q, 0);
    rst_n = 1'b1;

    // R1 R2 R4 R7: matrix and write-grant vectors
    foreach (VEC[i]) begin
      drive(1'b1, VEC[i][10:8], VEC[i][7:5], VEC[i][4], 3'd0, 32'h1000 + i);
      check($sformatf("R2 fault vec%0d", i), fault_code, VEC[i][3:1]);
      check($sformatf("R4 grant vec%0d", i), write_grant, VEC[i][0]);
      check($sformatf("R7 trap vec%0d", i), trap_req, VEC[i][3:1] != 0);
    end

    // R8: read with no fault clears
    idle_clear();
    check("R8 read clears fsr", fsr_q, 0);

    // R2: idle access has no effect
    drive(1'b0, 3'b000, 3'd6, 1'b1, 3'd4, 32'hDEAD0000);
    check("R2 idle fault_code", fault_code, 0);
    @(negedge clk);
    check("R2 idle fsr unchanged", fsr_q, 0);

    // R5 R6: first fault, user store perm5 -> idx4 type2 -> 0x8A
    drive(1'b1, 3'b100, 3'd5, 1'b1, 3'd0, 32'hA0001234);
    @(negedge clk);
    check("R5 first fault fsr", fsr_q, 8'h8A);
    check("R6 far first", far_q, 32'hA0001234);

    // R5: second fault without read, super load perm4 -> 1|0x20|0x08|2 = 0x2B
    chk_valid = 1'b1; {acc_store, acc_fetch, acc_super} = 3'b001; perm = 3'd4; vaddr = 32'hB0005678;
    @(negedge clk);
    check("R5 overflow fsr", fsr_q, 8'h2B);
    check("R6 far second", far_q, 32'hB0005678);

    // R6: no fault holds far
    drive(1'b1, 3'b001, 3'd0, 1'b1, 3'd0, 32'hC0000000);
    @(negedge clk);
    check("R6 far held", far_q, 32'hB0005678);

    // R3: walker translation error on user fetch -> 0x40|0x10|2 = 0x52
    idle_clear();
    drive(1'b1, 3'b010, 3'd3, 1'b1, 3'd4, 32'h00C0FFEE);
    check("R3 walker code 4", fault_code, 4);
    check("R3 no grant", write_grant, 0);
    @(negedge clk);
    check("R3 fsr type4", fsr_q, 8'h52);

    // R3: walker invalid on super store -> 0xA0|0x04|2 = 0xA6
    idle_clear();
    drive(1'b1, 3'b101, 3'd7, 1'b1, 3'd1, 32'h00000040);
    check("R3 walker code 1", fault_code, 1);
    @(negedge clk);
    check("R3 fsr type1", fsr_q, 8'hA6);

    // R7: no-fault mode suppresses trap but records
    idle_clear();
    nofault_mode = 1'b1;
    drive(1'b1, 3'b000, 3'd6, 1'b1, 3'd0, 32'h12340000);
    check("R7 nofault trap", trap_req, 0);
    @(negedge clk);
    check("R7 nofault fsr recorded", fsr_q, 8'h0E);
    nofault_mode = 1'b0;
    traps_en = 1'b0;
    idle_clear();
    drive(1'b1, 3'b000, 3'd6, 1'b1, 3'd0, 32'h56780000);
    check("R7 traps off", trap_req, 0);
    @(negedge clk);
    check("R7 traps off far", far_q, 32'h56780000);
    traps_en = 1'b1;

    // R9: fault in same cycle as read -> only new fault, no overflow
    drive(1'b1, 3'b100, 3'd5, 1'b1, 3'd0, 32'h0);
    @(negedge clk);
    check("R9 preload nonzero", fsr_q != 0, 1);
    chk_valid = 1'b1; {acc_store, acc_fetch, acc_super} = 3'b000; perm = 3'd6;
    vaddr = 32'h99990000; fsr_rd = 1'b1;
    @(negedge clk);
    fsr_rd = 1'b0; chk_valid = 1'b0;
    check("R9 read plus fault", fsr_q, 8'h0E);
    check("R9 far", far_q, 32'h99990000);

    // R10: reset again clears
    rst_n = 1'b0;
    #1;
    check("R10 reset fsr", fsr_q, 0);
    check("R10 reset far", far_q, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule